// File: doc/BRIEF.md
# Advanced Load Address Table

This block tracks loads that were moved above stores that might write the same memory. When such an advanced load issues, it records its destination register, the address it read and whether it deferred a fault. Each later store presents its address on a snoop port. Any valid entry whose address lies in the same 8-byte granule is marked as conflicted.

Before the loaded value is trusted, a check instruction looks up the entry by register number. The check can be one of two kinds. A check-load asks for a refetch when the entry is conflicted or missing, and it retires the entry. A check-advanced asks for a branch to recovery code under the same condition and leaves the entry in place. Both kinds report a deferred fault recorded for a hit entry. Memory access itself happens elsewhere.

Top module: `adv_load_table`

## Requirements
- R1: After reset no entry is valid. A check then reports no hit and a conflict, and a check-load then raises refetch.
- R2: An allocation records register, address and deferred-fault flag. A later check of that register reports a hit without a conflict.
- R3: A store snoop sets the conflict flag of every valid entry whose address matches in bits [63:3]. A snoop that matches no entry changes nothing.
- R4: A check-load (chk_adv=0) raises chk_reload when its entry is conflicted or absent. Whatever the result, it invalidates its entry at the clock edge.
- R5: A check-advanced (chk_adv=1) raises chk_recover when its entry is conflicted or absent, and it keeps the entry.
- R6: chk_fault is high when a check hits an entry recorded with the deferred-fault flag set, for either kind of check.
- R7: Allocating a register already in the table overwrites that entry's address and fault flag and clears its conflict flag.
- R8: A new register takes the lowest-numbered free entry. When no entry is free, it replaces entries in round-robin order starting at entry 0, and the pointer advances once per replacement.
- R9: When an allocation and a snoop occur in the same cycle, the allocation is applied first. A snoop matching the new address therefore conflicts the new entry.
- R10: Check outputs are combinational in the cycle chk_valid is high. They reflect only the updates of earlier cycles. On the same entry, an allocation wins over the invalidation by a check-load.
- R11: At most one valid entry holds a given register number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Advanced load records an entry |
| alloc_reg | input | REG_W | Destination register of the advanced load |
| alloc_addr | input | ADDR_W | Byte address read by the advanced load |
| alloc_fault | input | 1 | Advanced load deferred a fault |
| snoop_valid | input | 1 | A store is presenting its address |
| snoop_addr | input | ADDR_W | Store byte address |
| chk_valid | input | 1 | Check instruction present |
| chk_reg | input | REG_W | Register the check refers to |
| chk_adv | input | 1 | 0 = check-load, 1 = check-advanced |
| chk_hit | output | 1 | Valid entry found for chk_reg |
| chk_conflict | output | 1 | Entry conflicted or missing |
| chk_reload | output | 1 | Check-load must refetch |
| chk_recover | output | 1 | Check-advanced must branch to recovery |
| chk_fault | output | 1 | Deferred fault of the hit entry |

## Verification
Round-robin replacement is the hardest state to reach from the ports. It needs every entry filled, and then the pointer's position has to be inferred from which register later misses. The stimulus fills the table with sixteen distinct registers and allocates new ones. It then frees a middle slot with a check-load, to show that a free slot is used before the pointer. A long mixed stream with more registers than entries and a small address pool then keeps replacement, same-cycle allocate/snoop/check collisions and aliasing stores frequent. A behavioural model follows the stream every cycle.

// File: rtl/alt_pkg.sv
// Shared definitions for the advanced load address table.
// Assumes: the check kind is carried as one bit at the top ports.
package alt_pkg;
    typedef enum logic {
        CHK_LOAD = 1'b0,
        CHK_ADV  = 1'b1
    } chk_kind_e;

    localparam int GRAN_BITS_DEF = 3;
endpackage

// File: rtl/alt_lookup.sv
// Associative lookup: compares a key against the tags of all valid entries
// and returns the match vector, a hit flag and the lowest matching index.
// Assumes: the owner keeps tags unique among valid entries.
module alt_lookup #(
    parameter int N  = 16,
    parameter int KW = 7,
    localparam int IW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         valid,
    input  logic [N-1:0][KW-1:0] keys,
    input  logic [KW-1:0]        key,
    output logic [N-1:0]         hit_vec,
    output logic                 hit,
    output logic [IW-1:0]        idx
);
    // per-entry tag comparison
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = valid[i] && (keys[i] == key);
    end

    // priority encode the match vector
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (hit_vec[i]) idx = IW'(i);
        hit = |hit_vec;
    end

    // R11
    uniq_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/alt_victim.sv
// Picks the entry a new register is written to: the lowest free entry,
// or the round-robin pointer when the table is full.
// Assumes: advance is high only for allocations of registers not present.
module alt_victim #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  valid,
    input  logic          advance,
    output logic [IW-1:0] idx,
    output logic          full
);
    logic [IW-1:0] ptr_q;
    logic [IW-1:0] free_idx;

    // lowest free entry and fullness
    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (!valid[i]) free_idx = IW'(i);
        full = &valid;
        idx  = full ? ptr_q : free_idx;
    end

    // round-robin pointer moves once per replacement of a full table
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (advance && full)
            ptr_q <= (ptr_q == IW'(N - 1)) ? '0 : ptr_q + 1'b1;
    end

    // R8
    free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !full) |=> (ptr_q == $past(ptr_q)));
endmodule

// File: rtl/adv_load_table.sv
// Advanced load address table: records hoisted loads, flags entries hit by
// later stores at granule precision, and answers check-load / check-advanced
// lookups with hit, conflict, refetch, recovery and deferred-fault results.
// Assumes: at most one allocation, one snoop and one check per cycle.
// Per-cycle order: check sees prior state; then check-load invalidation,
// allocation write (wins over invalidation), then store snoop.
module adv_load_table
    import alt_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter int REG_W     = 7,
    parameter int ADDR_W    = 64,
    parameter int GRAN_BITS = GRAN_BITS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [REG_W-1:0]  alloc_reg,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              alloc_fault,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              chk_valid,
    input  logic [REG_W-1:0]  chk_reg,
    input  logic              chk_adv,
    output logic              chk_hit,
    output logic              chk_conflict,
    output logic              chk_reload,
    output logic              chk_recover,
    output logic              chk_fault
);
    localparam int IW = $clog2(ENTRIES);
    localparam logic [ADDR_W-1:0] GMASK = ~((ADDR_W'(1) << GRAN_BITS) - ADDR_W'(1));

    logic [ENTRIES-1:0]             v_q, cf_q, ft_q;
    logic [ENTRIES-1:0][REG_W-1:0]  tag_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] addr_q;

    logic [ENTRIES-1:0] ck_vec, al_vec, wr, inv;
    logic               ck_hit, al_hit, vic_full;
    logic [IW-1:0]      ck_idx, al_idx, vic_idx, wr_idx;
    logic [ADDR_W-1:0]  al_gaddr, sn_gaddr;
    chk_kind_e          kind;

    assign kind     = chk_kind_e'(chk_adv);
    assign al_gaddr = alloc_addr & GMASK;
    assign sn_gaddr = snoop_addr & GMASK;

    alt_lookup #(.N(ENTRIES), .KW(REG_W)) u_chk_lu (
        .clk(clk), .rst_n(rst_n), .valid(v_q), .keys(tag_q), .key(chk_reg),
        .hit_vec(ck_vec), .hit(ck_hit), .idx(ck_idx));

    alt_lookup #(.N(ENTRIES), .KW(REG_W)) u_alloc_lu (
        .clk(clk), .rst_n(rst_n), .valid(v_q), .keys(tag_q), .key(alloc_reg),
        .hit_vec(al_vec), .hit(al_hit), .idx(al_idx));

    alt_victim #(.N(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .valid(v_q),
        .advance(alloc_valid && !al_hit), .idx(vic_idx), .full(vic_full));

    assign wr_idx = al_hit ? al_idx : vic_idx;

    // check results from the state at the start of the cycle
    always_comb begin
        chk_hit      = chk_valid && ck_hit;
        chk_conflict = chk_valid && (!ck_hit || cf_q[ck_idx]);
        chk_reload   = chk_conflict && (kind == CHK_LOAD);
        chk_recover  = chk_conflict && (kind == CHK_ADV);
        chk_fault    = chk_hit && ft_q[ck_idx];
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic              v_n, cf_n, ft_n, snp;
        logic [REG_W-1:0]  tag_n;
        logic [ADDR_W-1:0] addr_n;

        // next state: invalidate, then allocate, then snoop
        always_comb begin
            wr[i]  = alloc_valid && (wr_idx == IW'(i));
            inv[i] = chk_valid && (kind == CHK_LOAD) && ck_hit && (ck_idx == IW'(i));
            v_n    = wr[i] || (v_q[i] && !inv[i]);
            tag_n  = wr[i] ? alloc_reg : tag_q[i];
            addr_n = wr[i] ? al_gaddr : addr_q[i];
            ft_n   = wr[i] ? alloc_fault : ft_q[i];
            snp    = snoop_valid && v_n && (addr_n == sn_gaddr);
            cf_n   = (wr[i] ? 1'b0 : cf_q[i]) || snp;
        end

        // entry storage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q[i]    <= 1'b0;
                cf_q[i]   <= 1'b0;
                ft_q[i]   <= 1'b0;
                tag_q[i]  <= '0;
                addr_q[i] <= '0;
            end else begin
                v_q[i]    <= v_n;
                cf_q[i]   <= cf_n;
                ft_q[i]   <= ft_n;
                tag_q[i]  <= tag_n;
                addr_q[i] <= addr_n;
            end
        end

        // R3
        snoop_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (snoop_valid && v_q[i] && (addr_q[i] == sn_gaddr) && !wr[i] && !inv[i])
            |=> cf_q[i]);

        // R7
        realloc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_valid && al_hit && (al_idx == IW'(i))
             && !(snoop_valid && (al_gaddr == sn_gaddr)))
            |=> (v_q[i] && !cf_q[i]));
    end

    // R4
    ld_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_adv && !alloc_valid) ##1
        (chk_valid && (chk_reg == $past(chk_reg))) |-> !chk_hit);

    // R5
    adv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_adv && chk_hit && !alloc_valid) ##1
        (chk_valid && (chk_reg == $past(chk_reg))) |-> chk_hit);
endmodule

// File: tb/test_adv_load_table.sv
module test_adv_load_table;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 0, alloc_fault = 0, snoop_valid = 0, chk_valid = 0, chk_adv = 0;
    logic [6:0]  alloc_reg = '0, chk_reg = '0;
    logic [63:0] alloc_addr = '0, snoop_addr = '0;
    logic chk_hit, chk_conflict, chk_reload, chk_recover, chk_fault;

    int vectors = 0;
    int errors  = 0;

    // behavioural reference model
    bit          m_v [16];
    bit          m_cf[16];
    bit          m_ft[16];
    int          m_tag[16];
    logic [63:0] m_addr[16];
    int          m_ptr;

    adv_load_table i_adv_load_table (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_reg(alloc_reg), .alloc_addr(alloc_addr),
        .alloc_fault(alloc_fault), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_adv(chk_adv),
        .chk_hit(chk_hit), .chk_conflict(chk_conflict), .chk_reload(chk_reload),
        .chk_recover(chk_recover), .chk_fault(chk_fault));

    always #10 clk = ~clk;

    function automatic int find(int r);
        for (int i = 0; i < 16; i++)
            if (m_v[i] && m_tag[i] == r) return i;
        return -1;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 16; i++) begin
            m_v[i] = 0; m_cf[i] = 0; m_ft[i] = 0; m_tag[i] = 0; m_addr[i] = '0;
        end
        m_ptr = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        alloc_valid = 0; snoop_valid = 0; chk_valid = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    // one cycle: drive, compare outputs against the model, advance the model
    task automatic step(bit av, int ar, logic [63:0] aa, bit af,
                        bit sv, logic [63:0] sa, bit cv, int cr, bit ca, string req);
        int ci, ai, fr;
        bit e_hit, e_cf;
        logic [4:0] exp_v, act_v;
        alloc_valid = av; alloc_reg = 7'(ar); alloc_addr = aa; alloc_fault = af;
        snoop_valid = sv; snoop_addr = sa;
        chk_valid = cv; chk_reg = 7'(cr); chk_adv = ca;
        #2;
        ci    = find(cr);
        e_hit = cv && (ci >= 0);
        e_cf  = cv && (ci < 0 || m_cf[ci]);
        exp_v = {e_hit, e_cf, e_cf && !ca, e_cf && ca, e_hit && m_ft[ci < 0 ? 0 : ci]};
        act_v = {chk_hit, chk_conflict, chk_reload, chk_recover, chk_fault};
        vectors++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: {hit,conf,reload,recover,fault} actual=%b expected=%b",
                     req, act_v, exp_v);
        end
        @(posedge clk);
        ai = -1;
        if (av) begin
            ai = find(ar);
            if (ai < 0) begin
                fr = -1;
                for (int i = 15; i >= 0; i--) if (!m_v[i]) fr = i;
                if (fr >= 0) ai = fr;
                else begin ai = m_ptr; m_ptr = (m_ptr + 1) % 16; end
            end
        end
        if (cv && !ca && ci >= 0) m_v[ci] = 0;
        if (ai >= 0) begin
            m_v[ai] = 1; m_tag[ai] = ar; m_addr[ai] = aa; m_ft[ai] = af; m_cf[ai] = 0;
        end
        if (sv)
            for (int i = 0; i < 16; i++)
                if (m_v[i] && (m_addr[i] >> 3) == (sa >> 3)) m_cf[i] = 1;
        @(negedge clk);
    endtask

    task automatic idle_chk(int cr, bit ca, string req);
        step(0, 0, '0, 0, 0, '0, 1, cr, ca, req);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        model_clear();
        @(negedge clk);
        do_reset();
        // R1: empty table after reset
        idle_chk(5, 0, "R1");
        idle_chk(5, 1, "R1");
        // R2: allocate then hit cleanly
        step(1, 3, 64'h1000, 0, 0, '0, 0, 0, 0, "R2");
        idle_chk(3, 1, "R2");
        // R3: non-matching store (next granule) leaves entry clean
        step(0, 0, '0, 0, 1, 64'h1008, 0, 0, 0, "R3");
        idle_chk(3, 1, "R3");
        // R3/R5: same-granule store conflicts, check-advanced recovers and keeps
        step(0, 0, '0, 0, 1, 64'h1007, 0, 0, 0, "R3");
        idle_chk(3, 1, "R5");
        idle_chk(3, 1, "R5");
        // R6/R4: faulting load, check-load reports fault then retires entry
        step(1, 4, 64'h2000, 1, 0, '0, 0, 0, 0, "R6");
        idle_chk(4, 1, "R6");
        idle_chk(4, 0, "R4");
        idle_chk(4, 0, "R4");
        // R7: reallocation clears conflict and moves address
        step(1, 3, 64'h3000, 0, 0, '0, 0, 0, 0, "R7");
        idle_chk(3, 1, "R7");
        step(0, 0, '0, 0, 1, 64'h1000, 0, 0, 0, "R7");
        idle_chk(3, 1, "R7");
        // R9: same-cycle allocate and matching snoop
        step(1, 9, 64'h4000, 0, 1, 64'h4004, 0, 0, 0, "R9");
        idle_chk(9, 1, "R9");
        // R10: check sees pre-cycle state; allocation wins over invalidation
        step(1, 9, 64'h5000, 0, 0, '0, 1, 9, 0, "R10");
        idle_chk(9, 1, "R10");
        step(1, 11, 64'h6000, 0, 0, '0, 1, 11, 1, "R10");

        // R8: fill, replace round-robin, then reuse a freed middle slot
        do_reset();
        for (int k = 0; k < 16; k++) step(1, 32 + k, 64'(k * 64), 0, 0, '0, 0, 0, 0, "R8");
        step(1, 60, 64'h9000, 0, 0, '0, 1, 32, 1, "R8");
        idle_chk(32, 1, "R8");
        step(1, 61, 64'h9100, 0, 0, '0, 1, 33, 1, "R8");
        idle_chk(33, 1, "R8");
        idle_chk(40, 0, "R8");
        step(1, 62, 64'h9200, 0, 0, '0, 1, 34, 1, "R8");
        step(1, 63, 64'h9300, 0, 0, '0, 1, 34, 1, "R8");
        idle_chk(34, 1, "R8");
        idle_chk(35, 1, "R8");

        // mixed stream exercising all rules together
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(0, 1) == 1, int'($urandom_range(0, 23)),
                 64'($urandom_range(0, 7) * 8 + $urandom_range(0, 9)), $urandom_range(0, 3) == 0,
                 $urandom_range(0, 2) == 0, 64'($urandom_range(0, 7) * 8 + $urandom_range(0, 9)),
                 $urandom_range(0, 1) == 1, int'($urandom_range(0, 23)), $urandom_range(0, 1) == 1,
                 "R2/R3/R4/R5/R6/R7/R8/R9/R10");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule